// File: doc/BRIEF.md
# Coprocessor Pipeline Follower

This block is an external coprocessor that runs in step with a host processor's pipeline. The host presents 32-bit instruction words. The follower keeps a shadow of them in four slots: decode, execute, memory and writeback. For the instruction in its decode slot it returns a two-bit handshake code every cycle. The host pipeline and the follower move together only on clock edges where the host's advance enable is high.

Instructions addressed to this unit can do four things:
- add two internal registers in one cycle;
- subtract two registers over several cycles;
- accept a burst of data words from the host into the register file;
- return a burst of register values to the host.

Register writes are never made early. The result or the load data travels down the slots with the instruction and reaches the register file only when it leaves writeback. This lets a missing pass, a late cancel or an abort discard the update without any undo logic.

Register reads happen when an instruction leaves decode and see only committed values. There is no forwarding, so dependent instructions must be spaced by the host.

Top module: `cp_follower`

## Requirements
- R1: After reset every slot is empty, `hs_code` is ABSENT (2'b10), `rdata_out` is zero and every register reads zero. The handshake encodings are WAIT 2'b00, GO 2'b01, ABSENT 2'b10 and LAST 2'b11.
- R2: While `if_en` is low, `hs_code` is ABSENT and an instruction presented with `instr_valid` is not taken, so it leaves no register change.
- R3: Slots, transfer positions and registers change only on a rising edge with `adv_en` high. While `adv_en` is low, `rdata_out` and the register file hold their values.
- R4: An add (opcode 1) shows LAST one edge after capture. Four advance edges after it leaves decode, register rd holds rd+rs, using the values read when it left decode.
- R5: An instruction whose `pass_in` is low at the edge that moves it from execute to memory is discarded and changes no register.
- R6: An instruction whose `late_cancel` is high at the edge that moves it from memory to writeback is discarded and changes no register.
- R7: `abort_in` high at the commit edge suppresses the register writes of a load, but not those of an add or subtract.
- R8: A load (opcode 3) of N words shows GO while words remain and LAST on the final word. It takes `wdata_in` on N successive advance edges into registers rd, rd+1, ... modulo the register count.
- R9: A store (opcode 4) of N words drives `rdata_out` with register rd+i (modulo the register count) while word i is pending, and changes no register. `rdata_out` is zero when no store sits in decode.
- R10: The burst count comes from `burst_len` at capture. A value of 0 is treated as 1, and a value above MAX_BURST is treated as MAX_BURST.
- R11: A subtract (opcode 2) shows WAIT for SLOW_CYC cycles after capture, then LAST, and holds decode meanwhile. It commits rd-rs like an add.
- R12: The instruction fields are: opcode bits 27:24, unit number bits 11:8, rd bits 16 upward, rs bits 12 upward. An instruction whose unit number differs from CP_ID gets ABSENT and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable; low forces ABSENT |
| adv_en | input | 1 | Pipeline advance enable from host |
| instr_valid | input | 1 | Instruction word present on `instr` |
| instr | input | 32 | Instruction word |
| burst_len | input | 4 | Words to move for a load or store |
| pass_in | input | 1 | Execute-slot instruction is to be executed |
| late_cancel | input | 1 | Drop the instruction leaving the memory slot |
| abort_in | input | 1 | Suppress the load committing from writeback |
| wdata_in | input | DW | Data word from host to coprocessor |
| hs_code | output | 2 | Decode-slot handshake code |
| rdata_out | output | DW | Data word from coprocessor to host |

## Verification
The handshake and the store data are due in the cycle that follows the edge that captures or advances the decode slot. The bench therefore samples both at the falling edge right after each rising edge. A register update is due on the third advance edge after the instruction leaves decode. The bench waits four advance edges after that before reading the register back through a store, so no read-back races a commit. Pass, late-cancel and abort are held constant across each instruction's whole flight, because only one instruction is in flight at a time. Each control therefore meets exactly the edge it is meant to gate.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
   typedef enum logic [1:0] {
      HS_WAIT   = 2'b00,
      HS_GO     = 2'b01,
      HS_ABSENT = 2'b10,
      HS_LAST   = 2'b11
   } hs_e;

   localparam logic [3:0] OP_ADD   = 4'd1;
   localparam logic [3:0] OP_SUB   = 4'd2;
   localparam logic [3:0] OP_LOAD  = 4'd3;
   localparam logic [3:0] OP_STORE = 4'd4;

   localparam int OP_LSB  = 24;
   localparam int CPN_LSB = 8;
   localparam int RD_LSB  = 16;
   localparam int RS_LSB  = 12;
endpackage

// File: rtl/cpf_decode.sv
module cpf_decode
   import cpf_pkg::*;
#(
   parameter int DW        = 32,
   parameter int NREG      = 8,
   parameter int MAX_BURST = 4,
   parameter int SLOW_CYC  = 3,
   parameter logic [3:0] CP_ID = 4'd6,
   localparam int RIDX_W = $clog2(NREG),
   localparam int IDX_W  = $clog2(MAX_BURST),
   localparam int CNT_W  = IDX_W + 1,
   localparam int BSY_W  = $clog2(SLOW_CYC + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    if_en,
   input  logic                    adv,
   input  logic                    instr_valid,
   input  logic [31:0]             instr,
   input  logic [3:0]              burst,
   input  logic [DW-1:0]           wdata,
   input  logic [DW-1:0]           rd_val,
   input  logic [DW-1:0]           rs_val,
   input  logic [DW-1:0]           st_val,
   output logic [RIDX_W-1:0]       rd_a,
   output logic [RIDX_W-1:0]       rs_a,
   output logic [RIDX_W-1:0]       st_a,
   output logic [1:0]              hs,
   output logic [DW-1:0]           rdata,
   output logic                    iss,
   output logic [RIDX_W-1:0]       iss_rd,
   output logic [CNT_W-1:0]        iss_nwr,
   output logic                    iss_load,
   output logic [MAX_BURST*DW-1:0] iss_data
);
   logic              d_vld;
   logic [3:0]        d_op;
   logic [RIDX_W-1:0] d_rd, d_rs;
   logic [IDX_W-1:0]  d_nm1, d_idx, nm1_new;
   logic [BSY_W-1:0]  busy;
   logic [DW-1:0]     stage [MAX_BURST];
   logic [DW-1:0]     alu;
   hs_e               hs_q;
   logic              unused_instr;

   assign unused_instr = ^instr;

   wire match    = instr[CPN_LSB +: 4] == CP_ID;
   wire accept   = if_en && instr_valid && match;
   wire is_load  = d_op == OP_LOAD;
   wire is_store = d_op == OP_STORE;
   wire is_xfer  = is_load || is_store;
   wire is_slow  = d_op == OP_SUB;
   wire last_w   = d_idx == d_nm1;
   wire hold     = d_vld && ((is_slow && busy != '0) || (is_xfer && !last_w));
   wire take     = adv && !hold;

   always_comb begin
      if (burst == 4'd0)
         nm1_new = '0;
      else if (32'(burst) > $unsigned(MAX_BURST))
         nm1_new = IDX_W'(MAX_BURST - 1);
      else
         nm1_new = IDX_W'(burst - 4'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_vld <= 1'b0;
         d_op  <= '0;
         d_rd  <= '0;
         d_rs  <= '0;
         d_nm1 <= '0;
         d_idx <= '0;
         busy  <= '0;
      end else begin
         if (take) begin
            d_vld <= accept;
            d_op  <= instr[OP_LSB +: 4];
            d_rd  <= instr[RD_LSB +: RIDX_W];
            d_rs  <= instr[RS_LSB +: RIDX_W];
            d_nm1 <= nm1_new;
            d_idx <= '0;
         end else if (adv && d_vld && is_xfer && !last_w) begin
            d_idx <= d_idx + IDX_W'(1);
         end
         if (take && accept && instr[OP_LSB +: 4] == OP_SUB)
            busy <= BSY_W'(SLOW_CYC);
         else if (busy != '0)
            busy <= busy - BSY_W'(1);
      end
   end

   // load staging buffer and outgoing payload, one lane per burst word
   for (genvar g = 0; g < MAX_BURST; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[g] <= '0;
         else if (adv && d_vld && is_load && !last_w && d_idx == IDX_W'(g))
            stage[g] <= wdata;
      end
      if (g == 0) begin : g_first
         assign iss_data[g*DW +: DW] = is_load ? ((d_idx == IDX_W'(g)) ? wdata : stage[g]) : alu;
      end else begin : g_rest
         assign iss_data[g*DW +: DW] = is_load ? ((d_idx == IDX_W'(g)) ? wdata : stage[g]) : '0;
      end
   end

   always_comb begin
      case (d_op)
         OP_ADD:  alu = rd_val + rs_val;
         OP_SUB:  alu = rd_val - rs_val;
         default: alu = '0;
      endcase
   end

   always_comb begin
      if (!if_en || !d_vld)          hs_q = HS_ABSENT;
      else if (is_slow && busy != '0) hs_q = HS_WAIT;
      else if (is_xfer && !last_w)    hs_q = HS_GO;
      else                            hs_q = HS_LAST;
   end

   assign hs       = hs_q;
   assign rd_a     = d_rd;
   assign rs_a     = d_rs;
   assign st_a     = d_rd + RIDX_W'(d_idx);
   assign rdata    = (d_vld && is_store) ? st_val : '0;
   assign iss      = adv && d_vld && !hold;
   assign iss_rd   = d_rd;
   assign iss_load = is_load;
   assign iss_nwr  = is_load ? CNT_W'(d_nm1) + CNT_W'(1) :
                     (d_op == OP_ADD || d_op == OP_SUB) ? CNT_W'(1) : '0;
endmodule

// File: rtl/cpf_tail.sv
module cpf_tail #(
   parameter int DW        = 32,
   parameter int MAX_BURST = 4,
   parameter int RIDX_W    = 3,
   parameter int CNT_W     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    adv,
   input  logic                    pass,
   input  logic                    lcancel,
   input  logic                    abort_w,
   input  logic                    iss,
   input  logic [RIDX_W-1:0]       iss_rd,
   input  logic [CNT_W-1:0]        iss_nwr,
   input  logic                    iss_load,
   input  logic [MAX_BURST*DW-1:0] iss_data,
   output logic                    wr_en,
   output logic [RIDX_W-1:0]       wr_rd,
   output logic [CNT_W-1:0]        wr_nwr,
   output logic [MAX_BURST*DW-1:0] wr_data
);
   logic                    e_vld, m_vld, w_vld;
   logic                    e_load, m_load, w_load;
   logic [RIDX_W-1:0]       e_rd, m_rd, w_rd;
   logic [CNT_W-1:0]        e_nwr, m_nwr, w_nwr;
   logic [MAX_BURST*DW-1:0] e_data, m_data, w_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_vld <= 1'b0; m_vld <= 1'b0; w_vld <= 1'b0;
         e_load <= 1'b0; m_load <= 1'b0; w_load <= 1'b0;
         e_rd <= '0; m_rd <= '0; w_rd <= '0;
         e_nwr <= '0; m_nwr <= '0; w_nwr <= '0;
         e_data <= '0; m_data <= '0; w_data <= '0;
      end else if (adv) begin
         e_vld  <= iss;
         e_load <= iss_load;
         e_rd   <= iss_rd;
         e_nwr  <= iss_nwr;
         e_data <= iss_data;
         m_vld  <= e_vld && pass;
         m_load <= e_load;
         m_rd   <= e_rd;
         m_nwr  <= e_nwr;
         m_data <= e_data;
         w_vld  <= m_vld && !lcancel;
         w_load <= m_load;
         w_rd   <= m_rd;
         w_nwr  <= m_nwr;
         w_data <= m_data;
      end
   end

   assign wr_en   = adv && w_vld && !(w_load && abort_w);
   assign wr_rd   = w_rd;
   assign wr_nwr  = w_nwr;
   assign wr_data = w_data;
endmodule

// File: rtl/cpf_regfile.sv
module cpf_regfile #(
   parameter int DW        = 32,
   parameter int NREG      = 8,
   parameter int MAX_BURST = 4,
   localparam int RIDX_W = $clog2(NREG),
   localparam int IDX_W  = $clog2(MAX_BURST),
   localparam int CNT_W  = IDX_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [RIDX_W-1:0]       wr_rd,
   input  logic [CNT_W-1:0]        wr_nwr,
   input  logic [MAX_BURST*DW-1:0] wr_data,
   input  logic [RIDX_W-1:0]       rd_a,
   input  logic [RIDX_W-1:0]       rs_a,
   input  logic [RIDX_W-1:0]       st_a,
   output logic [DW-1:0]           rd_val,
   output logic [DW-1:0]           rs_val,
   output logic [DW-1:0]           st_val
);
   logic [DW-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [RIDX_W-1:0] ofs;
      logic              hit;
      assign ofs = RIDX_W'(i) - wr_rd;
      assign hit = wr_en && (32'(ofs) < 32'(wr_nwr));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (hit)
            regs[i] <= wr_data[32'(ofs[IDX_W-1:0])*DW +: DW];
      end
   end

   assign rd_val = regs[rd_a];
   assign rs_val = regs[rs_a];
   assign st_val = regs[st_a];
endmodule

// File: rtl/cp_follower.sv
module cp_follower #(
   parameter int DW        = 32,
   parameter int NREG      = 8,
   parameter int MAX_BURST = 4,
   parameter int SLOW_CYC  = 3,
   parameter logic [3:0] CP_ID = 4'd6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          if_en,
   input  logic          adv_en,
   input  logic          instr_valid,
   input  logic [31:0]   instr,
   input  logic [3:0]    burst_len,
   input  logic          pass_in,
   input  logic          late_cancel,
   input  logic          abort_in,
   input  logic [DW-1:0] wdata_in,
   output logic [1:0]    hs_code,
   output logic [DW-1:0] rdata_out
);
   localparam int RIDX_W = $clog2(NREG);
   localparam int IDX_W  = $clog2(MAX_BURST);
   localparam int CNT_W  = IDX_W + 1;

   if (NREG < 2 || NREG > 16 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two from 2 to 16");
   end
   if (MAX_BURST < 2 || MAX_BURST > NREG || (MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_burst
      $error("MAX_BURST must be a power of two from 2 to NREG");
   end
   if (SLOW_CYC < 1) begin : g_bad_slow
      $error("SLOW_CYC must be at least 1");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8");
   end

   logic [RIDX_W-1:0]       rd_a, rs_a, st_a, iss_rd, wr_rd;
   logic [DW-1:0]           rd_val, rs_val, st_val;
   logic                    iss, iss_load, commit_en;
   logic [CNT_W-1:0]        iss_nwr, wr_nwr;
   logic [MAX_BURST*DW-1:0] iss_data, wr_data;

   cpf_decode #(
      .DW(DW), .NREG(NREG), .MAX_BURST(MAX_BURST), .SLOW_CYC(SLOW_CYC), .CP_ID(CP_ID)
   ) dec_i (
      .clk(clk), .rst_n(rst_n), .if_en(if_en), .adv(adv_en),
      .instr_valid(instr_valid), .instr(instr), .burst(burst_len), .wdata(wdata_in),
      .rd_val(rd_val), .rs_val(rs_val), .st_val(st_val),
      .rd_a(rd_a), .rs_a(rs_a), .st_a(st_a),
      .hs(hs_code), .rdata(rdata_out),
      .iss(iss), .iss_rd(iss_rd), .iss_nwr(iss_nwr), .iss_load(iss_load), .iss_data(iss_data)
   );

   cpf_tail #(
      .DW(DW), .MAX_BURST(MAX_BURST), .RIDX_W(RIDX_W), .CNT_W(CNT_W)
   ) tail_i (
      .clk(clk), .rst_n(rst_n), .adv(adv_en), .pass(pass_in), .lcancel(late_cancel),
      .abort_w(abort_in), .iss(iss), .iss_rd(iss_rd), .iss_nwr(iss_nwr),
      .iss_load(iss_load), .iss_data(iss_data),
      .wr_en(commit_en), .wr_rd(wr_rd), .wr_nwr(wr_nwr), .wr_data(wr_data)
   );

   cpf_regfile #(
      .DW(DW), .NREG(NREG), .MAX_BURST(MAX_BURST)
   ) rf_i (
      .clk(clk), .rst_n(rst_n), .wr_en(commit_en), .wr_rd(wr_rd), .wr_nwr(wr_nwr),
      .wr_data(wr_data), .rd_a(rd_a), .rs_a(rs_a), .st_a(st_a),
      .rd_val(rd_val), .rs_val(rs_val), .st_val(st_val)
   );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          if_en,
   input logic          adv_en,
   input logic          commit_en,
   input logic [1:0]    hs_code,
   input logic [DW-1:0] rdata_out
);
   AST_DISABLED_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      !if_en |-> hs_code == 2'b10); // R2
   AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> $stable(rdata_out)); // R3
   AST_COMMIT_ON_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |-> adv_en); // R3
   AST_WAIT_EXITS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && hs_code == 2'b00) |=> (!if_en || hs_code == 2'b00 || hs_code == 2'b11)); // R11
   AST_GO_HELD_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && !adv_en && hs_code == 2'b01) |=> (!if_en || hs_code == 2'b01)); // R8
   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (if_en && hs_code == 2'b10) |-> rdata_out == '0); // R9
endmodule

bind cp_follower cpf_checker #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .if_en(if_en), .adv_en(adv_en), .commit_en(commit_en),
   .hs_code(hs_code), .rdata_out(rdata_out)
);

// File: tb/cp_follower_tb_top.sv
module cp_follower_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] WAIT_C = 2'b00, GO_C = 2'b01, ABS_C = 2'b10, LAST_C = 2'b11;
   localparam logic [3:0] MY_CP = 4'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_en = 1'b1, adv_en = 1'b1, instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [3:0]  burst_len = 4'd1;
   logic        pass_in = 1'b1, late_cancel = 1'b0, abort_in = 1'b0;
   logic [31:0] wdata_in = '0;
   logic [1:0]  hs_code;
   logic [31:0] rdata_out;

   int checks = 0;
   int failures = 0;
   logic [31:0] mdl [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   cp_follower dut_i (
      .clk(clk), .rst_n(rst_n), .if_en(if_en), .adv_en(adv_en), .instr_valid(instr_valid),
      .instr(instr), .burst_len(burst_len), .pass_in(pass_in), .late_cancel(late_cancel),
      .abort_in(abort_in), .wdata_in(wdata_in), .hs_code(hs_code), .rdata_out(rdata_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] mk(input logic [3:0] op, input int rd, input int rs, input logic [3:0] cp);
      return {4'h0, op, 4'h0, 1'b0, 3'(rd), 1'b0, 3'(rs), cp, 8'h00};
   endfunction

   function automatic logic [31:0] word(input int s, input int i);
      return (32'(s) * 32'h9E37_79B1) ^ (32'(i) << 20) ^ 32'h0F0F_1234;
   endfunction

   function automatic int eff_n(input int b);
      return (b == 0) ? 1 : (b > 4) ? 4 : b;
   endfunction

   // R8 load burst, R10 clamping, R5/R6/R7 controls, R12 unit match
   task automatic do_load(input int rd, input int b, input int seed, input bit p, input bit lc,
                          input bit ab, input logic [3:0] cp, input string tag);
      int n = eff_n(b);
      bit m = (cp == MY_CP);
      pass_in = p; late_cancel = lc; abort_in = ab;
      instr = mk(4'd3, rd, 0, cp); burst_len = 4'(b); instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         if (m) chk({tag, " R8 load handshake"}, 32'(hs_code), 32'((i == n-1) ? LAST_C : GO_C));
         else   chk({tag, " R12 foreign unit absent"}, 32'(hs_code), 32'(ABS_C));
         wdata_in = word(seed, i);
         step();
      end
      repeat (4) step();
      chk({tag, " R1 idle absent after load"}, 32'(hs_code), 32'(ABS_C));
      if (m && p && !lc && !ab)
         for (int i = 0; i < n; i++) mdl[(rd + i) % 8] = word(seed, i);
      pass_in = 1'b1; late_cancel = 1'b0; abort_in = 1'b0;
   endtask

   // R4 add, R11 slow subtract
   task automatic do_alu(input logic [3:0] op, input int rd, input int rs, input bit p,
                         input bit lc, input bit ab, input string tag);
      logic [31:0] res;
      pass_in = p; late_cancel = lc; abort_in = ab;
      instr = mk(op, rd, rs, MY_CP); instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      if (op == 4'd2)
         for (int k = 0; k < 3; k++) begin
            chk({tag, " R11 wait phase"}, 32'(hs_code), 32'(WAIT_C));
            step();
         end
      chk({tag, " R4 single-cycle last"}, 32'(hs_code), 32'(LAST_C));
      res = (op == 4'd1) ? mdl[rd] + mdl[rs] : mdl[rd] - mdl[rs];
      step();
      repeat (4) step();
      if (p && !lc) mdl[rd] = res;
      pass_in = 1'b1; late_cancel = 1'b0; abort_in = 1'b0;
   endtask

   // R9 store read-back
   task automatic do_store(input int rd, input int b, input string tag);
      int n = eff_n(b);
      instr = mk(4'd4, rd, 0, MY_CP); burst_len = 4'(b); instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      for (int i = 0; i < n; i++) begin
         chk({tag, " R9 store handshake"}, 32'(hs_code), 32'((i == n-1) ? LAST_C : GO_C));
         chk({tag, " R9 store data"}, rdata_out, mdl[(rd + i) % 8]);
         step();
      end
      chk({tag, " R9 data zero when idle"}, rdata_out, 32'h0);
   endtask

   task automatic read_all(input string tag);
      do_store(0, 4, tag);
      do_store(4, 4, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset handshake", 32'(hs_code), 32'(ABS_C));
      chk("R1 reset data", rdata_out, 32'h0);
      read_all("R1 reset registers");

      // load sweep: every start register and burst length, with wrap
      for (int rd = 0; rd < 8; rd++)
         for (int b = 1; b <= 4; b++) begin
            do_load(rd, b, rd * 8 + b, 1'b1, 1'b0, 1'b0, MY_CP, "R8 sweep");
            do_store(rd, b, "R8 sweep readback");
         end

      // R10 burst clamping
      do_load(3, 0, 101, 1'b1, 1'b0, 1'b0, MY_CP, "R10 zero burst");
      read_all("R10 zero burst");
      do_load(6, 9, 102, 1'b1, 1'b0, 1'b0, MY_CP, "R10 over burst");
      read_all("R10 over burst");
      do_load(1, 15, 103, 1'b1, 1'b0, 1'b0, MY_CP, "R10 max code");
      do_store(1, 0, "R10 store zero burst");
      do_store(5, 12, "R10 store over burst");

      // R5 R6 R7 sweep over pass / late cancel / abort combinations
      for (int c = 0; c < 8; c++) begin
         do_load(c, 2, 200 + c, c[0], c[1], c[2], MY_CP, "R5 R6 R7 load");
         read_all("R5 R6 R7 load");
         do_alu(4'd1, c, (c + 3) % 8, c[0], c[1], c[2], "R5 R6 R7 add");
         read_all("R5 R6 R7 add");
      end

      // R4 add and R11 subtract sweep
      for (int a = 0; a < 8; a++) begin
         do_alu(4'd1, a, (a + 5) % 8, 1'b1, 1'b0, 1'b0, "R4 add");
         do_alu(4'd2, (a + 2) % 8, a, 1'b1, 1'b0, 1'b0, "R11 sub");
      end
      do_alu(4'd1, 4, 4, 1'b1, 1'b0, 1'b0, "R4 add self");
      read_all("R4 R11 results");

      // R12 foreign unit number
      do_load(2, 3, 300, 1'b1, 1'b0, 1'b0, 4'd5, "R12 foreign");
      do_load(0, 4, 301, 1'b1, 1'b0, 1'b0, 4'd7, "R12 foreign");
      read_all("R12 foreign ignored");

      // R2 interface disabled: instruction not taken
      if_en = 1'b0;
      instr = mk(4'd3, 0, 0, MY_CP); burst_len = 4'd4; instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      chk("R2 disabled absent", 32'(hs_code), 32'(ABS_C));
      for (int i = 0; i < 6; i++) begin
         wdata_in = 32'hDEAD_0000 + 32'(i);
         step();
      end
      chk("R2 disabled absent later", 32'(hs_code), 32'(ABS_C));
      if_en = 1'b1;
      read_all("R2 disabled no write");

      // R2 disable during an in-flight store forces ABSENT only
      instr = mk(4'd4, 0, 0, MY_CP); burst_len = 4'd1; instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      adv_en = 1'b0; if_en = 1'b0;
      #1 chk("R2 forced absent", 32'(hs_code), 32'(ABS_C));
      if_en = 1'b1;
      #1 chk("R2 restored last", 32'(hs_code), 32'(LAST_C));
      adv_en = 1'b1;
      step();

      // R3 stall in the middle of a store
      instr = mk(4'd4, 2, 0, MY_CP); burst_len = 4'd3; instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      adv_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
         step();
         chk("R3 stall handshake", 32'(hs_code), 32'(GO_C));
         chk("R3 stall data", rdata_out, mdl[2]);
      end
      adv_en = 1'b1;
      for (int i = 0; i < 3; i++) begin
         chk("R3 resumed data", rdata_out, mdl[2 + i]);
         step();
      end

      // R3 stall while an add is in flight: commit waits for advance edges
      instr = mk(4'd1, 7, 6, MY_CP); instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      step();
      adv_en = 1'b0;
      repeat (10) step();
      adv_en = 1'b1;
      step();
      adv_en = 1'b0;
      repeat (3) step();
      adv_en = 1'b1;
      instr = mk(4'd4, 7, 0, MY_CP); burst_len = 4'd1; instr_valid = 1'b1;
      step();
      instr_valid = 1'b0;
      chk("R3 not yet committed", rdata_out, mdl[7]);
      step();
      repeat (4) step();
      mdl[7] = mdl[7] + mdl[6];
      do_store(7, 1, "R3 committed after advances");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule